// File: doc/BRIEF.md
# Single-Chamber Pacing Escape Timer

This block times the pacing of one heart chamber, atrium or ventricle. It counts a one-millisecond tick strobe and watches a sense event from the chamber. It issues a one-clock pace strobe whenever the chamber stays silent for too long. A mode input sets how the block answers a sense: it can ignore sensing, it can answer every sense with an immediate pace, or it can let a sense cancel the pending pace.

The block is a three-state machine. In `ST_FIRST` the escape window after reset is the full lower-rate interval. Any chamber event moves it to `ST_BLANK`. That event can be a pace, a triggered sense or an inhibiting sense. In `ST_BLANK` sensing is off for the upper-rate interval. When blanking ends (`BLANK->ESCAPE`), the machine enters `ST_ESCAPE`. There the window is the lower-rate interval less the upper-rate interval. A timeout or an accepted sense in `ST_FIRST` or `ST_ESCAPE` takes the transition `EVENT->BLANK`. With no sensing, one pace therefore falls every lower-rate interval. Both intervals are live inputs, so a rate controller outside the block can move the lower-rate interval while the block runs.

Top module: `pacer_chamber_fsm`

## Requirements
- R1: After reset `pace` is low and the first escape window is the full `lri_ticks`. With no accepted sense, `pace` is high in the clock cycle after the cycle that carries the `lri_ticks`-th tick counted from reset.
- R2: After any chamber event, `sense_en` stays low for `uri_ticks` ticks. A sense in that time changes neither the pace timing nor the outputs.
- R3: After blanking, the escape window is `lri_ticks - uri_ticks` ticks. With no accepted sense, consecutive paces are therefore exactly `lri_ticks` ticks apart.
- R4: Mode codes 0 and 3 are asynchronous. In these modes `sense_en` is always low, `sense` has no effect, and a pace falls every `lri_ticks` ticks.
- R5: Mode code 1 is triggered. An accepted sense (`sense` high while `sense_en` is high) gives a pace in the next clock cycle and starts blanking.
- R6: Mode code 2 is inhibited. An accepted sense gives no pace, drops `sense_en` in the next cycle, and restarts the cycle. The next pace then falls `lri_ticks` ticks after the last tick before the sense.
- R7: `pace` is never high for two consecutive clock cycles.
- R8: When `uri_ticks >= lri_ticks`, the escape window is clamped to zero. The pace falls on the first tick after blanking ends, which gives pace spacing of `uri_ticks + 1` ticks.
- R9: When an accepted sense and an escape timeout fall in the same tick cycle, the sense wins. In inhibited mode no pace follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe every millisecond |
| sense | input | 1 | Chamber activity detected this cycle |
| mode | input | 2 | Response to sensing: 0/3 none, 1 triggered, 2 inhibited |
| lri_ticks | input | 12 | Lower-rate interval in ticks |
| uri_ticks | input | 12 | Upper-rate interval in ticks |
| pace | output | 1 | One-cycle pace strobe |
| sense_en | output | 1 | High while a sense would be accepted |

## Verification
A sense and an escape timeout can land in the same clock cycle, and the two call for opposite actions. The bench provokes this on purpose. It uses its reference model to tell which upcoming tick cycle ends the escape window, and drives `sense` high in exactly that cycle while in inhibited mode. It then expects no pace in the next cycle, `sense_en` low, and the following pace one full lower-rate interval later. Sense pulses during blanking and in asynchronous mode are also compared against the model every clock, so that a sense which should be ignored cannot shift the timing unnoticed.

// File: rtl/pacer_pkg.sv
`timescale 1ns/1ps
package pacer_pkg;
    typedef enum logic [1:0] {
        RESP_NONE     = 2'd0,
        RESP_TRIG     = 2'd1,
        RESP_INHIB    = 2'd2,
        RESP_NONE_ALT = 2'd3
    } resp_e;

    typedef enum logic [1:0] {
        ST_FIRST  = 2'd0,
        ST_BLANK  = 2'd1,
        ST_ESCAPE = 2'd2
    } phase_e;
endpackage

// File: rtl/pacer_window.sv
`timescale 1ns/1ps
module pacer_window #(
    parameter int IW = 12
) (
    input  logic [IW-1:0] lri,
    input  logic [IW-1:0] uri,
    output logic [IW-1:0] win
);
    // Escape window after blanking; clamped to zero if the rates are inverted.
    always_comb begin
        if (lri > uri) win = lri - uri;
        else           win = '0;
    end
endmodule

// File: rtl/pacer_tick_counter.sv
`timescale 1ns/1ps
module pacer_tick_counter #(
    parameter int IW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic [IW-1:0] limit,
    output logic          expire
);
    localparam logic [IW-1:0] CNT_MAX = '1;

    logic [IW-1:0] cnt;
    logic [IW:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + 1'b1;
    // A limit of zero expires on the first tick.
    assign expire  = tick && (cnt_inc >= {1'b0, limit});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt <= '0;
        else if (clear)                 cnt <= '0;
        else if (tick && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    // R3: every phase starts counting from zero
    a_r3_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));
    // R1: the counter never moves between ticks
    a_r1_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(cnt));
endmodule

// File: rtl/pacer_chamber_fsm.sv
`timescale 1ns/1ps
module pacer_chamber_fsm
    import pacer_pkg::*;
#(
    parameter int IW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          sense,
    input  logic [1:0]    mode,
    input  logic [IW-1:0] lri_ticks,
    input  logic [IW-1:0] uri_ticks,
    output logic          pace,
    output logic          sense_en
);
    resp_e          resp;
    phase_e         state, state_n;
    logic [IW-1:0]  win;
    logic [IW-1:0]  limit;
    logic           expire;
    logic           responsive;
    logic           sense_ok;
    logic           pace_n;
    logic           phase_clear;

    assign resp       = resp_e'(mode);
    assign responsive = (resp == RESP_TRIG) || (resp == RESP_INHIB);

    pacer_window #(.IW(IW)) u_window (
        .lri (lri_ticks),
        .uri (uri_ticks),
        .win (win)
    );

    always_comb begin
        unique case (state)
            ST_FIRST:  limit = lri_ticks;
            ST_BLANK:  limit = uri_ticks;
            ST_ESCAPE: limit = win;
            default:   limit = lri_ticks;
        endcase
    end

    pacer_tick_counter #(.IW(IW)) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (phase_clear),
        .tick   (tick),
        .limit  (limit),
        .expire (expire)
    );

    assign sense_ok = sense && sense_en;

    // Next state and pace decision; a sense outranks a same-tick timeout.
    always_comb begin
        state_n = state;
        pace_n  = 1'b0;
        unique case (state)
            ST_FIRST, ST_ESCAPE: begin
                if (sense_ok) begin
                    state_n = ST_BLANK;
                    pace_n  = (resp == RESP_TRIG);
                end else if (expire) begin
                    state_n = ST_BLANK;
                    pace_n  = 1'b1;
                end
            end
            ST_BLANK: begin
                if (expire) state_n = ST_ESCAPE;
            end
            default: state_n = ST_FIRST;
        endcase
    end

    assign phase_clear = (state_n != state);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FIRST;
        else        state <= state_n;
    end

    // Output register and status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pace <= 1'b0;
        else        pace <= pace_n;
    end

    assign sense_en = responsive && (state != ST_BLANK);

    a_r7_pace_single: assert property (@(posedge clk) disable iff (!rst_n)
        pace |=> !pace);
    a_r2_blank_after_pace: assert property (@(posedge clk) disable iff (!rst_n)
        pace |-> !sense_en);
    a_r5_trig_pace: assert property (@(posedge clk) disable iff (!rst_n)
        (sense && sense_en && resp == RESP_TRIG) |=> pace);
    a_r6_inhib_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (sense && sense_en && resp == RESP_INHIB) |=> (!pace && !sense_en));
    // R9: a sense on a timeout tick in inhibited mode still yields no pace
    a_r9_sense_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (sense && sense_en && expire && resp == RESP_INHIB) |=> !pace);
endmodule

// File: tb/pacer_chamber_fsm_test.sv
`timescale 1ns/1ps
module pacer_chamber_fsm_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        sense = 1'b0;
    logic [1:0]  mode = 2'd2;
    logic [11:0] lri_ticks = 12'd20;
    logic [11:0] uri_ticks = 12'd8;
    logic        pace;
    logic        sense_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int div = 0;
    int tick_no = 0;
    string tag = "R1";

    // behavioural reference: phase 0 first window, 1 blanking, 2 escape
    int m_ph = 0;
    int m_el = 0;
    bit m_pace = 0;
    bit hit_done = 0;

    always #5 clk = ~clk;

    pacer_chamber_fsm uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sense(sense), .mode(mode),
        .lri_ticks(lri_ticks), .uri_ticks(uri_ticks),
        .pace(pace), .sense_en(sense_en)
    );

    function automatic int m_limit();
        int l = int'(lri_ticks);
        int u = int'(uri_ticks);
        if (m_ph == 0) return l;
        if (m_ph == 1) return u;
        return (l > u) ? l - u : 0;
    endfunction

    function automatic bit m_sen();
        return (m_ph != 1) && (mode == 2'd1 || mode == 2'd2);
    endfunction

    task automatic check(input string req, input int act, input int exp_v, input string what);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp_v, cycles);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic model_step(input bit s, input bit t);
        bit to;
        bit ok;
        to = t && (m_el + 1 >= m_limit());
        ok = s && m_sen();
        m_pace = 0;
        if (m_ph != 1) begin
            if (ok) begin m_ph = 1; m_el = 0; m_pace = (mode == 2'd1); end
            else if (to) begin m_ph = 1; m_el = 0; m_pace = 1; end
            else if (t) m_el++;
        end else begin
            if (to) begin m_ph = 2; m_el = 0; end
            else if (t) m_el++;
        end
    endtask

    // One clock: drive at negedge, compare shortly after the posedge.
    task automatic cyc(input bit s, input bit hit = 0);
        bit s_eff;
        @(negedge clk);
        tick = (div == 3);
        div = (div + 1) % 4;
        if (tick) tick_no++;
        s_eff = s;
        hit_done = 0;
        if (hit && tick && m_ph != 1 && (m_el + 1 >= m_limit())) begin
            s_eff = 1;
            hit_done = 1;
        end
        sense = s_eff;
        @(posedge clk);
        #1;
        model_step(s_eff, tick);
        check(tag, pace, m_pace, "pace vs model");
        check(tag, sense_en, m_sen(), "sense_en vs model");
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    endtask

    task automatic wait_pace(input bit s_pat, output int at_tick);
        int n = 0;
        at_tick = -1;
        while (n < 4000) begin
            cyc(s_pat && (n % 7 == 3));
            if (pace) begin at_tick = tick_no; return; end
            n++;
        end
    endtask

    initial begin
        int t0;
        int t1;
        int ts;
        repeat (3) @(posedge clk);
        #1;
        check("R1", pace, 0, "pace in reset");
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", pace, 0, "pace after reset");
        check("R1", sense_en, 1, "sense_en after reset, inhibited");

        // R1 first window, R3 later spacing
        tag = "R1";
        wait_pace(0, t0);
        check("R1", t0, 20, "tick of first pace");
        tag = "R3";
        wait_pace(0, t1);
        check("R3", t1 - t0, 20, "pace spacing");
        t0 = t1;

        // R2: senses during blanking are ignored
        tag = "R2";
        for (int i = 0; i < 12; i++) cyc(i % 3 == 1);
        check("R2", sense_en, 0, "sense_en during blanking");
        wait_pace(0, t1);
        check("R2", t1 - t0, 20, "spacing with blanked senses");
        t0 = t1;

        // R6: inhibited sense restarts the cycle
        tag = "R6";
        while (!sense_en) cyc(0);
        repeat (10) cyc(0);
        ts = tick_no;
        cyc(1);
        check("R6", pace, 0, "no pace after inhibiting sense");
        check("R6", sense_en, 0, "blanking after inhibiting sense");
        wait_pace(0, t1);
        check("R6", t1 - ts, 20, "spacing after inhibiting sense");

        // R5: triggered sense paces next cycle
        tag = "R5";
        mode = 2'd1;
        while (!sense_en) cyc(0);
        repeat (9) cyc(0);
        cyc(1);
        check("R5", pace, 1, "pace after triggered sense");
        cyc(0);
        check("R7", pace, 0, "pace width one cycle");

        // R9: sense on the timeout tick, inhibited mode
        tag = "R9";
        mode = 2'd2;
        while (!hit_done) cyc(0, 1);
        check("R9", pace, 0, "sense beats same-tick timeout");
        check("R9", sense_en, 0, "blanking after same-tick sense");
        ts = tick_no;
        wait_pace(0, t1);
        check("R9", t1 - ts, 20, "spacing after same-tick sense");

        // R4: asynchronous modes ignore sensing
        tag = "R4";
        mode = 2'd0;
        wait_pace(1, t0);
        check("R4", sense_en, 0, "sense_en low, mode 0");
        wait_pace(1, t1);
        check("R4", t1 - t0, 20, "async spacing, mode 0");
        mode = 2'd3;
        wait_pace(1, t0);
        check("R4", t0 - t1, 20, "async spacing, mode 3");
        check("R4", sense_en, 0, "sense_en low, mode 3");

        // R8: inverted rates clamp the escape window
        tag = "R8";
        mode = 2'd2;
        lri_ticks = 12'd6;
        uri_ticks = 12'd10;
        wait_pace(0, t0);
        wait_pace(0, t1);
        check("R8", t1 - t0, 11, "clamped spacing");
        wait_pace(0, t0);
        check("R8", t0 - t1, 11, "clamped spacing again");

        finish_run();
    end
endmodule